// File: doc/BRIEF.md
# Second-Chance Frame Replacement Controller

This block keeps track of a fixed set of physical memory frames and decides, for each incoming page reference, whether the page is already resident and which frame it lands in. Each frame has an occupied flag, the page number it holds and one recently-used bit. The frames form a ring that a rotating pointer (the hand) walks around. A reference that finds its page is a hit: the frame's used bit is set and the hand stays put. A reference that misses starts a sweep from the hand. Free frames are taken at once. Frames whose used bit is clear are evicted. Frames whose used bit is set lose the bit and are passed over.

A client presents a page number with a valid strobe while `busy` is low. The block answers with a single-cycle result strobe. The result carries the hit flag, the frame index, and, when a resident page was thrown out, an eviction flag with the old page number. Moving page contents and any backing-store traffic belong to the surrounding system.

Top module: `clk_repl_engine`

## Requirements
- R1: After reset every frame is free, all used bits are 0, the hand is at frame 0, `busy` is 0 and `result_valid` is 0. The first miss after reset therefore fills frame 0 with `result_evicted` = 0.
- R2: A reference to a resident page is answered in the next cycle with `result_hit` = 1, `result_frame` set to the frame holding the page and `result_evicted` = 0. The hand does not move.
- R3: A hit sets the used bit of the frame that was hit, so the next sweep passes over that frame once.
- R4: On a miss, a free frame under the hand receives the new page with `result_evicted` = 0, and the hand advances by one.
- R5: On a miss, an occupied frame under the hand whose used bit is 0 is replaced. The result reports `result_evicted` = 1, the previous page in `result_victim`, and that frame index. The hand advances by one.
- R6: On a miss, a frame under the hand whose used bit is 1 has the bit cleared and is skipped. Each frame examined takes one cycle, so a miss that skips k frames is answered k+2 cycles after the reference is taken.
- R7: A newly loaded page starts with its used bit set to 1.
- R8: The hand moves from the last frame (NUM_FRAMES-1) back to frame 0.
- R9: `busy` is 1 from the cycle after a miss is accepted until its result is given. A reference presented while `busy` is 1 is ignored and produces no result.
- R10: A sweep examines at most NUM_FRAMES+1 frames before it places the page.
- R11: Every accepted reference produces exactly one single-cycle `result_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | Page reference strobe, taken when busy is 0 |
| ref_page | input | PAGE_W | Page number being referenced |
| busy | output | 1 | A sweep is in progress and new references are ignored |
| result_valid | output | 1 | One-cycle strobe marking a result |
| result_hit | output | 1 | 1 = page was resident, 0 = miss |
| result_frame | output | $clog2(NUM_FRAMES) | Frame that holds the page after the reference |
| result_evicted | output | 1 | A resident page was thrown out |
| result_victim | output | PAGE_W | Page number that was thrown out (0 when none) |

## Verification
A hit is due on the clock edge right after the reference is taken. A miss is due k+2 edges after the reference is taken, where k is the number of frames skipped because their used bit was set. The bench works out k for each reference from its own model of the ring. It drives inputs on falling edges, counts rising edges until `result_valid` appears, and compares that count with the expected latency. It also samples `busy` one edge after a miss and checks that `result_valid` is low on the edge after each pulse.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;
endpackage

// File: rtl/clk_repl_ring_inc.sv
module clk_repl_ring_inc #(
    parameter int NUM_FRAMES = 4,
    parameter int IDX_W      = 2
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nxt
);
    generate
        if ((NUM_FRAMES & (NUM_FRAMES - 1)) == 0) begin : g_pow2
            assign nxt = idx + 1'b1;
        end else begin : g_cmp
            assign nxt = (idx == IDX_W'(NUM_FRAMES - 1)) ? '0 : idx + 1'b1;
        end
    endgenerate
endmodule

// File: rtl/clk_repl_match.sv
module clk_repl_match #(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    parameter int IDX_W      = 2
) (
    input  logic [NUM_FRAMES-1:0]        occ,
    input  logic [NUM_FRAMES*PAGE_W-1:0] pages,
    input  logic [PAGE_W-1:0]            probe,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    logic [NUM_FRAMES-1:0] eq;

    generate
        for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
            assign eq[g] = occ[g] && (pages[g*PAGE_W +: PAGE_W] == probe);
        end
    endgenerate

    // lowest matching frame wins; at most one matches in normal use
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/clk_repl_engine.sv
module clk_repl_engine
    import clk_repl_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int PAGE_W     = 8,
    localparam int IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_valid,
    input  logic [PAGE_W-1:0] ref_page,
    output logic              busy,
    output logic              result_valid,
    output logic              result_hit,
    output logic [IDX_W-1:0]  result_frame,
    output logic              result_evicted,
    output logic [PAGE_W-1:0] result_victim
);
    typedef struct packed {
        sweep_state_e                st;
        logic [IDX_W-1:0]            hand;
        logic [NUM_FRAMES-1:0]       occ;
        logic [NUM_FRAMES-1:0]       used;
        logic [NUM_FRAMES*PAGE_W-1:0] pages;
        logic [PAGE_W-1:0]           pend;
        logic                        rv;
        logic                        rhit;
        logic [IDX_W-1:0]            rframe;
        logic                        revict;
        logic [PAGE_W-1:0]           rvictim;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic             look_hit;
    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] hand_nxt;
    logic [PAGE_W-1:0] hand_page;
    logic             accept;

    clk_repl_match #(
        .NUM_FRAMES(NUM_FRAMES),
        .PAGE_W    (PAGE_W),
        .IDX_W     (IDX_W)
    ) u_match (
        .occ    (st_q.occ),
        .pages  (st_q.pages),
        .probe  (ref_page),
        .hit    (look_hit),
        .hit_idx(look_idx)
    );

    clk_repl_ring_inc #(
        .NUM_FRAMES(NUM_FRAMES),
        .IDX_W     (IDX_W)
    ) u_inc (
        .idx(st_q.hand),
        .nxt(hand_nxt)
    );

    assign hand_page = st_q.pages[st_q.hand*PAGE_W +: PAGE_W];
    assign accept    = ref_valid && (st_q.st == ST_IDLE);

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        if (accept) begin
            if (look_hit) begin
                st_d.used[look_idx] = 1'b1;
                st_d.rv      = 1'b1;
                st_d.rhit    = 1'b1;
                st_d.rframe  = look_idx;
                st_d.revict  = 1'b0;
                st_d.rvictim = '0;
            end else begin
                st_d.st   = ST_SWEEP;
                st_d.pend = ref_page;
            end
        end else if (st_q.st == ST_SWEEP) begin
            if (!st_q.occ[st_q.hand] || !st_q.used[st_q.hand]) begin
                st_d.occ[st_q.hand]  = 1'b1;
                st_d.used[st_q.hand] = 1'b1;
                st_d.pages[st_q.hand*PAGE_W +: PAGE_W] = st_q.pend;
                st_d.rv      = 1'b1;
                st_d.rhit    = 1'b0;
                st_d.rframe  = st_q.hand;
                st_d.revict  = st_q.occ[st_q.hand];
                st_d.rvictim = st_q.occ[st_q.hand] ? hand_page : '0;
                st_d.hand    = hand_nxt;
                st_d.st      = ST_IDLE;
            end else begin
                st_d.used[st_q.hand] = 1'b0;
                st_d.hand = hand_nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy           = (st_q.st == ST_SWEEP);
    assign result_valid   = st_q.rv;
    assign result_hit     = st_q.rhit;
    assign result_frame   = st_q.rframe;
    assign result_evicted = st_q.revict;
    assign result_victim  = st_q.rvictim;

    // sweep length counter, used only by the bound check below
    logic [IDX_W+1:0] sweep_steps_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_steps_q <= '0;
        end else if (st_q.st == ST_SWEEP) begin
            sweep_steps_q <= sweep_steps_q + 1'b1;
        end else begin
            sweep_steps_q <= '0;
        end
    end

    a_r10_sweep_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_SWEEP) |-> (sweep_steps_q <= (IDX_W+2)'(NUM_FRAMES)));

    a_r2_hit_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && look_hit) |=> (result_valid && result_hit && !result_evicted
                                  && result_frame == $past(look_idx)));

    a_r2_hit_hand_still: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && look_hit) |=> $stable(st_q.hand));

    a_r9_busy_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !look_hit) |=> (busy && !result_valid));

    a_r5_hit_never_evicts: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && result_hit) |-> !result_evicted);

    a_r7_loaded_is_used: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !result_hit) |-> st_q.used[result_frame]);

    a_r6_hand_moves_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$stable(st_q.hand));
endmodule

// File: tb/clk_repl_engine_tb.sv
module clk_repl_engine_tb;
    localparam int N  = 4;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [PW-1:0] ref_page = '0;
    logic          busy;
    logic          result_valid;
    logic          result_hit;
    logic [1:0]    result_frame;
    logic          result_evicted;
    logic [PW-1:0] result_victim;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    clk_repl_engine #(.NUM_FRAMES(N), .PAGE_W(PW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_valid     (ref_valid),
        .ref_page      (ref_page),
        .busy          (busy),
        .result_valid  (result_valid),
        .result_hit    (result_hit),
        .result_frame  (result_frame),
        .result_evicted(result_evicted),
        .result_victim (result_victim)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        ref_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // present one reference and check its answer and latency
    task automatic send_ref(input string req, input int page, input int ex_hit,
                            input int ex_frame, input int ex_evict, input int ex_victim,
                            input int ex_lat);
        int lat;
        @(negedge clk);
        ref_valid = 1'b1;
        ref_page  = PW'(page);
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        ref_valid = 1'b0;
        if (ex_hit == 0 && ex_lat > 1) check("R9", "busy after miss", int'(busy), 1);
        while (!result_valid && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check(req, "latency", lat, ex_lat);
        check(req, "hit", int'(result_hit), ex_hit);
        check(req, "frame", int'(result_frame), ex_frame);
        check(req, "evicted", int'(result_evicted), ex_evict);
        if (ex_evict != 0) check(req, "victim", int'(result_victim), ex_victim);
        @(negedge clk);
        check("R11", "pulse length", int'(result_valid), 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "busy", int'(busy), 0);
        check("R1", "result_valid", int'(result_valid), 0);
        send_ref("R1", 5, 0, 0, 0, 0, 2);
    endtask

    task automatic t_sequence();
        do_reset();
        send_ref("R4", 1, 0, 0, 0, 0, 2);
        send_ref("R4", 3, 0, 1, 0, 0, 2);
        send_ref("R4", 4, 0, 2, 0, 0, 2);
        send_ref("R8", 7, 0, 3, 0, 0, 2);
        send_ref("R2", 1, 1, 0, 0, 0, 1);
        // all four used bits set: four skips, wrap to frame 0 (R7 R8 R10)
        send_ref("R6", 2, 0, 0, 1, 1, 6);
        send_ref("R3", 4, 1, 2, 0, 0, 1);
        send_ref("R5", 1, 0, 1, 1, 3, 2);
        // frame 2 was hit, so it is skipped once (R3)
        send_ref("R3", 3, 0, 3, 1, 7, 3);
        send_ref("R2", 4, 1, 2, 0, 0, 1);
    endtask

    task automatic t_hit_keeps_hand();
        do_reset();
        send_ref("R4", 1, 0, 0, 0, 0, 2);
        send_ref("R4", 2, 0, 1, 0, 0, 2);
        send_ref("R2", 1, 1, 0, 0, 0, 1);
        send_ref("R2", 3, 0, 2, 0, 0, 2);
    endtask

    task automatic t_busy_ignore();
        int pulses;
        do_reset();
        send_ref("R4", 1, 0, 0, 0, 0, 2);
        send_ref("R4", 2, 0, 1, 0, 0, 2);
        send_ref("R4", 3, 0, 2, 0, 0, 2);
        send_ref("R4", 4, 0, 3, 0, 0, 2);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_page  = 8'd9;
        @(posedge clk);
        @(negedge clk);
        ref_page = 8'd10;
        check("R9", "busy during sweep", int'(busy), 1);
        @(posedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
        pulses = 0;
        for (int i = 0; i < 12; i++) begin
            if (result_valid) begin
                pulses++;
                check("R10", "frame after full sweep", int'(result_frame), 0);
                check("R5", "victim after full sweep", int'(result_victim), 1);
            end
            @(negedge clk);
        end
        check("R9", "results while busy", pulses, 1);
        // page 10 must not be resident: hand at 1, used bit clear there
        send_ref("R9", 10, 0, 1, 1, 2, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sequence();
        t_hit_keeps_hand();
        t_busy_ignore();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule